// File: doc/BRIEF.md
# Translation Exception Code Builder

This block assembles the diagnostic record that accompanies an address-translation or access-register fault. When a fault is reported it takes the interruption code, the faulting 64-bit logical address, the access mode, the current address-space identifier, the access-register number and, for protection faults, a qualifier that says which kind of protection tripped. From these it builds a packed 64-bit exception identification word and an 8-bit access id, and it stores both, together with the code, in an info register.

Which fields get filled depends on the class of the code. The classes nest. A protection fault gets protection-kind bits on top of everything a table-walk fault gets. A table-walk fault gets the page address, the fetch/store indication and the space identifier, on top of what an access-list fault gets. An access-list fault gets only the access id. Any other code leaves the word and the access id at zero. The info register loads only when a fault strobe is present and otherwise keeps its contents, so the record of the most recent fault stays readable until the next one.

Top module: `tec_builder`

## Requirements
- R1: While reset is asserted and after its release, before any strobe, `info_code`, `info_tec` and `info_access_id` are all zero.
- R2: The outputs change only at a rising clock edge where `req_valid` is 1. Input changes while `req_valid` is 0 have no effect on the outputs.
- R3: At the edge that samples `req_valid`=1, `info_code` takes the value of `exc_code` unchanged, whatever its class.
- R4: For code 0x0004 (protection), the word bits at vector positions 7, 3 and 2 depend on `prot_type`. Type 0 (low-address) sets 7. Type 1 (key) sets 3. Type 2 (access-list) sets 3 and 2. Type 3 (translation) sets 2. Type 4 (execute) sets 7 and 2. Types 5 to 7 set none of them. For every other code, `prot_type` has no effect on the outputs, and these three bits are zero.
- R5: For protection and for the table-walk codes 0x0010, 0x0011, 0x0038, 0x0039, 0x003A and 0x003B, `info_tec[63:12]` equals `fault_addr[63:12]`, which is the address shifted right by 12.
- R6: For the same codes as R5, `info_tec[11:10]` is 1 when `acc_mode` is 1 (store). It is 2 when `acc_mode` is 0 (fetch) or 2 (instruction fetch).
- R7: For the same codes as R5, `info_tec[1:0]` equals `space_id`.
- R8: For the codes of R5 and for the access-list codes 0x0028 to 0x002C, `info_access_id` equals `ar_num`. For the access-list codes, `info_tec` is zero.
- R9: For any code in none of the sets above, `info_tec` and `info_access_id` are zero.
- R10: Bits 9:8 and 6:4 of `info_tec` are always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Fault strobe; loads the info register |
| exc_code | input | 16 | Interruption code of the fault |
| prot_type | input | 3 | Protection-kind qualifier, used with code 0x0004 only |
| fault_addr | input | 64 | Faulting logical address |
| ar_num | input | 8 | Access-register number |
| acc_mode | input | 2 | 0 fetch, 1 store, 2 instruction fetch |
| space_id | input | 2 | Current address-space identifier |
| info_code | output | 16 | Latched interruption code |
| info_tec | output | 64 | Latched exception identification word |
| info_access_id | output | 8 | Latched access id |

## Verification
The hardest cases to reach are those where an input must be shown to have no effect. These include a non-zero protection qualifier arriving with a table-walk or access-list code, and full-scale address, mode and space inputs arriving with a code outside every class. The stimulus drives every input to a value that would leave a visible trace, so a leak shows up as a wrong bit. The other hard case is retention. The bench sends strobes back to back and then keeps toggling every data input while the strobe is low, and it checks that the last captured record does not change.

// File: rtl/tec_pkg.sv
package tec_pkg;

  localparam int EXC_W = 16;

  typedef enum logic [1:0] {
    CLS_OTHER = 2'd0,
    CLS_ALIST = 2'd1,
    CLS_WALK  = 2'd2,
    CLS_PROT  = 2'd3
  } exc_class_e;

  localparam logic [1:0] ACC_FETCH  = 2'd0;
  localparam logic [1:0] ACC_STORE  = 2'd1;
  localparam logic [1:0] ACC_IFETCH = 2'd2;

  localparam logic [1:0] FSI_STORE = 2'd1;
  localparam logic [1:0] FSI_FETCH = 2'd2;

  localparam logic [2:0] PROT_LOWADDR = 3'd0;
  localparam logic [2:0] PROT_KEY     = 3'd1;
  localparam logic [2:0] PROT_ALIST   = 3'd2;
  localparam logic [2:0] PROT_XLATE   = 3'd3;
  localparam logic [2:0] PROT_EXEC    = 3'd4;

  localparam logic [EXC_W-1:0] EXC_PROTECTION = 16'h0004;

  localparam int N_WALK = 6;
  localparam logic [EXC_W-1:0] WALK_CODES [N_WALK] = '{
    16'h0010, 16'h0011, 16'h0038, 16'h0039, 16'h003A, 16'h003B
  };

  localparam int N_ALIST = 5;
  localparam logic [EXC_W-1:0] ALIST_CODES [N_ALIST] = '{
    16'h0028, 16'h0029, 16'h002A, 16'h002B, 16'h002C
  };

  // vector positions of the protection-kind flags in the word
  localparam int POS_LA_FLAG  = 7;
  localparam int POS_KEY_FLAG = 3;
  localparam int POS_DAT_FLAG = 2;

  typedef struct packed {
    logic la_flag;
    logic key_flag;
    logic dat_flag;
  } prot_flags_t;

endpackage

// File: rtl/tec_class_decode.sv
module tec_class_decode
  import tec_pkg::*;
#(
  parameter int CODE_W = EXC_W
) (
  input  logic [CODE_W-1:0] code,
  output exc_class_e        cls
);

  logic [N_WALK-1:0]  walk_hit;
  logic [N_ALIST-1:0] alist_hit;

  for (genvar g = 0; g < N_WALK; g++) begin : g_walk
    assign walk_hit[g] = (code == CODE_W'(WALK_CODES[g]));
  end

  for (genvar g = 0; g < N_ALIST; g++) begin : g_alist
    assign alist_hit[g] = (code == CODE_W'(ALIST_CODES[g]));
  end

  always_comb begin
    if (code == CODE_W'(EXC_PROTECTION)) begin
      cls = CLS_PROT;
    end else if (|walk_hit) begin
      cls = CLS_WALK;
    end else if (|alist_hit) begin
      cls = CLS_ALIST;
    end else begin
      cls = CLS_OTHER;
    end
  end

endmodule

// File: rtl/tec_prot_flags.sv
module tec_prot_flags
  import tec_pkg::*;
(
  input  logic        enable,
  input  logic [2:0]  kind,
  output prot_flags_t flags
);

  always_comb begin
    flags = '0;
    if (enable) begin
      unique case (kind)
        PROT_LOWADDR: flags.la_flag  = 1'b1;
        PROT_KEY:     flags.key_flag = 1'b1;
        PROT_ALIST: begin
          flags.key_flag = 1'b1;
          flags.dat_flag = 1'b1;
        end
        PROT_XLATE:   flags.dat_flag = 1'b1;
        PROT_EXEC: begin
          flags.la_flag  = 1'b1;
          flags.dat_flag = 1'b1;
        end
        default:      flags = '0;
      endcase
    end
  end

endmodule

// File: rtl/tec_word_pack.sv
module tec_word_pack
  import tec_pkg::*;
#(
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12
) (
  input  logic                     fill_walk,
  input  prot_flags_t              flags,
  input  logic [ADDR_W-PAGE_SHIFT-1:0] page_num,
  input  logic [1:0]               mode,
  input  logic [1:0]               space,
  output logic [ADDR_W-1:0]        word
);

  localparam int FSI_HI = PAGE_SHIFT - 1;
  localparam int FSI_LO = PAGE_SHIFT - 2;

  always_comb begin
    word = '0;
    if (fill_walk) begin
      word[ADDR_W-1:PAGE_SHIFT] = page_num;
      word[FSI_HI:FSI_LO]       = (mode == ACC_STORE) ? FSI_STORE : FSI_FETCH;
      word[1:0]                 = space;
    end
    word[POS_LA_FLAG]  = flags.la_flag;
    word[POS_KEY_FLAG] = flags.key_flag;
    word[POS_DAT_FLAG] = flags.dat_flag;
  end

endmodule

// File: rtl/tec_builder.sv
module tec_builder
  import tec_pkg::*;
#(
  parameter int CODE_W     = EXC_W,
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int AR_W       = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [CODE_W-1:0] exc_code,
  input  logic [2:0]        prot_type,
  input  logic [ADDR_W-1:0] fault_addr,
  input  logic [AR_W-1:0]   ar_num,
  input  logic [1:0]        acc_mode,
  input  logic [1:0]        space_id,
  output logic [CODE_W-1:0] info_code,
  output logic [ADDR_W-1:0] info_tec,
  output logic [AR_W-1:0]   info_access_id
);

  localparam int PFN_W = ADDR_W - PAGE_SHIFT;

  // reset: asserted asynchronously, released through two flops
  logic rst_meta_q;
  logic rst_sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_sync_q <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_sync_q <= rst_meta_q;
    end
  end

  exc_class_e  cls;
  prot_flags_t flags;
  logic [ADDR_W-1:0] word;
  logic        is_prot;
  logic        fill_walk;
  logic        fill_id;
  logic        unused_low_addr;

  assign unused_low_addr = ^fault_addr[PAGE_SHIFT-1:0];

  tec_class_decode #(.CODE_W(CODE_W)) u_decode (
    .code (exc_code),
    .cls  (cls)
  );

  // cascaded population: protection ⊃ table walk ⊃ access list
  assign is_prot   = (cls == CLS_PROT);
  assign fill_walk = is_prot || (cls == CLS_WALK);
  assign fill_id   = fill_walk || (cls == CLS_ALIST);

  tec_prot_flags u_flags (
    .enable (is_prot),
    .kind   (prot_type),
    .flags  (flags)
  );

  tec_word_pack #(.ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT)) u_pack (
    .fill_walk (fill_walk),
    .flags     (flags),
    .page_num  (fault_addr[ADDR_W-1:PAGE_SHIFT]),
    .mode      (acc_mode),
    .space     (space_id),
    .word      (word)
  );

  logic [CODE_W-1:0] code_q, code_d;
  logic [ADDR_W-1:0] tec_q,  tec_d;
  logic [AR_W-1:0]   aid_q,  aid_d;
  logic              load_en;

  assign load_en = req_valid;

  always_comb begin
    code_d = code_q;
    tec_d  = tec_q;
    aid_d  = aid_q;
    if (load_en) begin
      code_d = exc_code;
      tec_d  = word;
      aid_d  = fill_id ? ar_num : '0;
    end
  end

  always_ff @(posedge clk or negedge rst_sync_q) begin
    if (!rst_sync_q) begin
      code_q <= '0;
      tec_q  <= '0;
      aid_q  <= '0;
    end else if (load_en) begin
      code_q <= code_d;
      tec_q  <= tec_d;
      aid_q  <= aid_d;
    end
  end

  assign info_code      = code_q;
  assign info_tec       = tec_q;
  assign info_access_id = aid_q;

endmodule

// File: rtl/tec_builder_chk.sv
module tec_builder_chk
  import tec_pkg::*;
#(
  parameter int CODE_W     = EXC_W,
  parameter int ADDR_W     = 64,
  parameter int PAGE_SHIFT = 12,
  parameter int AR_W       = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [CODE_W-1:0] exc_code,
  input logic [2:0]        prot_type,
  input logic [ADDR_W-1:0] fault_addr,
  input logic [AR_W-1:0]   ar_num,
  input logic [1:0]        acc_mode,
  input logic [1:0]        space_id,
  input logic [CODE_W-1:0] info_code,
  input logic [ADDR_W-1:0] info_tec,
  input logic [AR_W-1:0]   info_access_id
);

  logic in_walk_set;
  logic in_alist_set;
  logic is_prot_code;
  logic unused_chk_low;

  assign unused_chk_low = ^fault_addr[PAGE_SHIFT-1:0];
  assign is_prot_code   = (exc_code == CODE_W'(EXC_PROTECTION));

  always_comb begin
    in_walk_set  = is_prot_code;
    in_alist_set = 1'b0;
    for (int i = 0; i < N_WALK; i++)
      if (exc_code == CODE_W'(WALK_CODES[i])) in_walk_set = 1'b1;
    for (int i = 0; i < N_ALIST; i++)
      if (exc_code == CODE_W'(ALIST_CODES[i])) in_alist_set = 1'b1;
  end

  assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(info_code) && $stable(info_tec) && $stable(info_access_id)));

  assert_code_capture_R3: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (info_code == $past(exc_code)));

  assert_dat_flag_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && is_prot_code && prot_type == PROT_XLATE) |=>
      (info_tec[2] && !info_tec[3] && !info_tec[7]));

  assert_page_addr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_walk_set) |=>
      (info_tec[ADDR_W-1:PAGE_SHIFT] == $past(fault_addr[ADDR_W-1:PAGE_SHIFT])));

  assert_fsi_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_walk_set) |=>
      (info_tec[PAGE_SHIFT-1:PAGE_SHIFT-2] ==
       (($past(acc_mode) == ACC_STORE) ? FSI_STORE : FSI_FETCH)));

  assert_space_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && in_walk_set) |=> (info_tec[1:0] == $past(space_id)));

  assert_access_id_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && (in_walk_set || in_alist_set)) |=> (info_access_id == $past(ar_num)));

  assert_other_clear_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !in_walk_set && !in_alist_set) |=>
      (info_tec == '0 && info_access_id == '0));

  assert_reserved_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (info_tec[9:8] == 2'b00 && info_tec[6:4] == 3'b000));

endmodule

bind tec_builder tec_builder_chk #(
  .CODE_W(CODE_W), .ADDR_W(ADDR_W), .PAGE_SHIFT(PAGE_SHIFT), .AR_W(AR_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .exc_code(exc_code),
  .prot_type(prot_type), .fault_addr(fault_addr), .ar_num(ar_num),
  .acc_mode(acc_mode), .space_id(space_id), .info_code(info_code),
  .info_tec(info_tec), .info_access_id(info_access_id)
);

// File: tb/tec_builder_tb.sv
module tec_builder_tb;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [15:0] exc_code;
  logic [2:0]  prot_type;
  logic [63:0] fault_addr;
  logic [7:0]  ar_num;
  logic [1:0]  acc_mode;
  logic [1:0]  space_id;
  logic [15:0] info_code;
  logic [63:0] info_tec;
  logic [7:0]  info_access_id;

  int n_checks = 0;
  int n_fails  = 0;
  bit done     = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  tec_builder u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .exc_code(exc_code),
    .prot_type(prot_type), .fault_addr(fault_addr), .ar_num(ar_num),
    .acc_mode(acc_mode), .space_id(space_id), .info_code(info_code),
    .info_tec(info_tec), .info_access_id(info_access_id)
  );

  typedef struct {
    logic [15:0] code;
    logic [63:0] tec;
    logic [7:0]  aid;
    string       tag;
  } exp_t;

  exp_t sb_q[$];
  exp_t last_exp;

  function automatic bit is_walk(input logic [15:0] c);
    return (c == 16'h0004) || (c == 16'h0010) || (c == 16'h0011) ||
           (c == 16'h0038) || (c == 16'h0039) || (c == 16'h003A) || (c == 16'h003B);
  endfunction

  function automatic bit is_alist(input logic [15:0] c);
    return (c >= 16'h0028) && (c <= 16'h002C);
  endfunction

  function automatic exp_t model(input logic [15:0] c, input logic [2:0] pt,
                                 input logic [63:0] a, input logic [7:0] ar,
                                 input logic [1:0] m, input logic [1:0] s,
                                 input string tag);
    exp_t e;
    e.code = c; e.tec = '0; e.aid = '0; e.tag = tag;
    if (c == 16'h0004) begin
      case (pt)
        3'd0: e.tec[7] = 1'b1;
        3'd1: e.tec[3] = 1'b1;
        3'd2: begin e.tec[3] = 1'b1; e.tec[2] = 1'b1; end
        3'd3: e.tec[2] = 1'b1;
        3'd4: begin e.tec[7] = 1'b1; e.tec[2] = 1'b1; end
        default: ;
      endcase
    end
    if (is_walk(c)) begin
      e.tec[63:12] = a[63:12];
      e.tec[11:10] = (m == 2'd1) ? 2'd1 : 2'd2;
      e.tec[1:0]   = s;
    end
    if (is_walk(c) || is_alist(c)) e.aid = ar;
    return e;
  endfunction

  task automatic check(input bit ok, input string req, input string act, input string expv);
    n_checks++;
    if (!ok) begin
      n_fails++;
      $display("FAIL %s actual=%s expected=%s", req, act, expv);
    end
  endtask

  task automatic compare(input exp_t e, input string where);
    check(info_code == e.code && info_tec == e.tec && info_access_id == e.aid,
          {e.tag, " ", where},
          $sformatf("code=%h tec=%h aid=%h", info_code, info_tec, info_access_id),
          $sformatf("code=%h tec=%h aid=%h", e.code, e.tec, e.aid));
  endtask

  // driver: presents one fault and queues its expected record
  task automatic send(input logic [15:0] c, input logic [2:0] pt, input logic [63:0] a,
                      input logic [7:0] ar, input logic [1:0] m, input logic [1:0] s,
                      input string tag);
    @(negedge clk);
    exc_code = c; prot_type = pt; fault_addr = a; ar_num = ar; acc_mode = m; space_id = s;
    req_valid = 1'b1;
    sb_q.push_back(model(c, pt, a, ar, m, s, tag));
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // monitor: compares just after each capturing edge
  always @(posedge clk) begin
    if (rst_n && req_valid) begin
      #1;
      if (sb_q.size() == 0) begin
        check(1'b0, "R3", "unexpected capture", "queued item");
      end else begin
        last_exp = sb_q.pop_front();
        compare(last_exp, "capture");
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog R2 actual=hung expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req_valid = 1'b0; exc_code = '0; prot_type = '0;
    fault_addr = '0; ar_num = '0; acc_mode = '0; space_id = '0;
    repeat (3) @(negedge clk);
    // R1: reset values
    check(info_code == 16'h0, "R1", $sformatf("%h", info_code), "0000");
    check(info_tec == 64'h0, "R1", $sformatf("%h", info_tec), "0");
    check(info_access_id == 8'h0, "R1", $sformatf("%h", info_access_id), "00");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(info_tec == 64'h0 && info_code == 16'h0, "R1 post-release",
          $sformatf("%h", info_tec), "0");

    // R4/R5/R6/R7: every protection kind, store access
    for (int k = 0; k < 8; k++)
      send(16'h0004, 3'(k), 64'hDEAD_BEEF_1234_5FFF + 64'(k << 12), 8'(8'h10 + k),
           2'd1, 2'(k), $sformatf("R4 R5 R6 prot kind %0d", k));
    idle();

    // R6: fetch and instruction fetch report fetch
    send(16'h0011, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h0F, 2'd0, 2'd3, "R6 R7 fetch");
    idle();
    send(16'h0011, 3'd0, 64'h0000_0000_0000_1000, 8'h0E, 2'd2, 2'd2, "R6 ifetch");
    idle();

    // R5/R7/R8: each table-walk code, with a protection qualifier that must be ignored (R4)
    send(16'h0010, 3'd4, 64'h0123_4567_89AB_CDEF, 8'h01, 2'd1, 2'd1, "R5 R4 walk 10");
    send(16'h0038, 3'd0, 64'h8000_0000_0000_0000, 8'h02, 2'd0, 2'd0, "R5 walk 38");
    send(16'h0039, 3'd2, 64'h7FFF_FFFF_FFFF_F000, 8'h03, 2'd2, 2'd3, "R5 walk 39");
    send(16'h003A, 3'd1, 64'hA5A5_A5A5_A5A5_A5A5, 8'h04, 2'd1, 2'd2, "R5 walk 3A");
    send(16'h003B, 3'd3, 64'h5A5A_5A5A_5A5A_5A5A, 8'hFF, 2'd0, 2'd1, "R7 walk 3B");
    idle();

    // R8: access-list codes carry only the access id
    for (int c = 16'h28; c <= 16'h2C; c++)
      send(16'(c), 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 8'(8'hA0 + c), 2'd1, 2'd3,
           $sformatf("R8 alist %h", c));
    idle();

    // R9/R10: codes outside every class
    send(16'h0005, 3'd4, 64'hFFFF_FFFF_FFFF_FFFF, 8'hFF, 2'd1, 2'd3, "R9 R10 code 05");
    send(16'h0012, 3'd2, 64'hFFFF_FFFF_FFFF_FFFF, 8'h77, 2'd0, 2'd3, "R9 code 12");
    send(16'h0104, 3'd0, 64'hFFFF_FFFF_FFFF_FFFF, 8'h33, 2'd1, 2'd1, "R9 R3 code 0104");
    send(16'h003C, 3'd3, 64'h1234_0000_0000_0000, 8'h44, 2'd2, 2'd2, "R9 code 3C");
    idle();

    // R2: last record held while inputs toggle with the strobe low
    send(16'h003B, 3'd0, 64'hCAFE_F00D_0000_0000, 8'h5C, 2'd1, 2'd2, "R2 R3 last");
    idle();
    for (int i = 0; i < 4; i++) begin
      exc_code = 16'h0004; prot_type = 3'(i); fault_addr = ~fault_addr;
      ar_num = ~ar_num; acc_mode = 2'(i); space_id = 2'(~i);
      @(negedge clk);
      compare(last_exp, "R2 hold");
    end

    repeat (2) @(negedge clk);
    check(sb_q.size() == 0, "R3", $sformatf("%0d pending", sb_q.size()), "0 pending");
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fails);
    $finish;
  end

endmodule